// File: doc/BRIEF.md
# Control-Flow Single-Step Controller

This block holds the debug-control flags that decide how a processor core single-steps. Software can arm it to step on every retired instruction, as with plain single-stepping, or only on control transfers: a taken branch, a serviced interrupt or a raised exception. A control-transfer request is taken in the cycle after its strobe. The block then raises a one-cycle debug-exception request and writes back the cleared flag values, so that the debugger has to re-arm before stepping can go on.

Three flags live here: the transfer-step flag, the trace-message flag and the branch-record flag. The trap flag stays in the core's flags register and comes in on `tf_in`. When the block asks the flags register to clear it, `tf_clr` goes high. Software reads the three flags back on `ctl_flags` and writes them with `sw_we`/`sw_wdata`.

The controller is a Moore machine with five states. `ST_IDLE` is disarmed. `ST_STEP_INSN` is armed for instruction stepping. `ST_STEP_XFER` is armed for transfer stepping. `ST_TRAP_INSN` and `ST_TRAP_XFER` are the two request states. The transitions are:
- ARM_INSN (trap flag set, transfer-step flag clear) and ARM_XFER (both set) go from `ST_IDLE` or an armed state to the matching armed state.
- DISARM (trap flag clear) goes back to `ST_IDLE`.
- FIRE_INSN goes from `ST_STEP_INSN` to `ST_TRAP_INSN` on a retire strobe.
- FIRE_XFER goes from `ST_STEP_XFER` to `ST_TRAP_XFER` on any transfer strobe.
- RECOVER goes from either request state to `ST_IDLE` unconditionally.

Top module: `cf_step_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `ctl_flags` is 0, `dbg_req` is 0 and `tf_clr` is 0.
- R2: A write with `sw_we` high loads `sw_wdata` into `ctl_flags`, visible in the next cycle. The bit positions are: bit 0 transfer-step, bit 1 trace-message, bit 2 branch-record.
- R3: The block is armed for transfer stepping when `tf_in` and bit 0 were both high in the previous cycle. In that case a nonzero `xfer_evt` in cycle N drives `dbg_req` and `tf_clr` high for exactly cycle N+1. The strobe bits are: bit 0 taken branch, bit 1 serviced interrupt, bit 2 exception.
- R4: When a transfer request is raised, bits 0 and 2 of `ctl_flags` read 0 in the request cycle and bit 1 keeps its earlier value.
- R5: After a transfer request, no transfer strobe raises a request until bit 0 is written to 1 again, even if `tf_in` is set once more.
- R6: The block is armed for instruction stepping when `tf_in` was high and bit 0 was low in the previous cycle. In that case `retire_evt` in cycle N gives `dbg_req` high and `tf_clr` low in cycle N+1, clears bit 2, and leaves bits 0 and 1 unchanged.
- R7: When `tf_in` is low, no strobe raises a request and no flag is cleared.
- R8: Any mix of strobes in one cycle gives a single one-cycle request. Strobes in the two cycles after a strobe that raised a request are ignored.
- R9: Arming follows the flags one cycle late. A transfer strobe in the cycle right after the write that sets bit 0 raises no request, and one a cycle later does.
- R10: A software write in the same cycle as a request-raising strobe still raises the request, but `ctl_flags` takes the written value instead of the cleared one.
- R11: When armed for transfers, `retire_evt` alone raises no request. When armed for instructions, `xfer_evt` alone raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tf_in | input | 1 | Trap flag from the core's flags register |
| xfer_evt | input | XFER_W (3) | Per-cycle strobes: taken branch, serviced interrupt, exception |
| retire_evt | input | 1 | Instruction retired this cycle |
| sw_we | input | 1 | Software write of the flag word |
| sw_wdata | input | 3 | Flag word to write |
| ctl_flags | output | 3 | Current flag word (software read) |
| dbg_req | output | 1 | Single-step debug-exception request |
| tf_clr | output | 1 | Clear the trap flag in the flags register |

## Verification
A wrong state or flag shows at the ports within two cycles. A lost arming shows up as a missing `dbg_req` in the cycle after a strobe. A missed clear shows up as a second request two cycles after the first, or as a stale bit on `ctl_flags` in the request cycle itself. The most error-prone points are the one-cycle arming lag, the dead cycles after a request, and the clash between a software write and an automatic clear. For that reason the stimulus lines strobes up against each of those cycles, and random traffic re-arms the block often.

// File: rtl/cfss_pkg.sv
package cfss_pkg;

    localparam int FLAG_W    = 3;
    localparam int BIT_XSTEP = 0;
    localparam int BIT_MSG   = 1;
    localparam int BIT_REC   = 2;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_STEP_INSN = 3'd1,
        ST_STEP_XFER = 3'd2,
        ST_TRAP_INSN = 3'd3,
        ST_TRAP_XFER = 3'd4
    } cfss_state_e;

    typedef enum logic [1:0] {
        FIRE_NONE = 2'd0,
        FIRE_INSN = 2'd1,
        FIRE_XFER = 2'd2
    } cfss_fire_e;

endpackage

// File: rtl/cfss_trigger.sv
module cfss_trigger
    import cfss_pkg::*;
#(
    parameter int XFER_W = 3
) (
    input  cfss_state_e       state,
    input  logic [XFER_W-1:0] xfer_evt,
    input  logic              retire_evt,
    output cfss_fire_e        fire
);

    logic [XFER_W:0] or_chain;
    logic            any_xfer;

    assign or_chain[0] = 1'b0;
    for (genvar g = 0; g < XFER_W; g++) begin : g_or
        assign or_chain[g+1] = or_chain[g] | xfer_evt[g];
    end
    assign any_xfer = or_chain[XFER_W];

    always_comb begin
        unique case (state)
            ST_STEP_XFER: fire = any_xfer   ? FIRE_XFER : FIRE_NONE;
            ST_STEP_INSN: fire = retire_evt ? FIRE_INSN : FIRE_NONE;
            default:      fire = FIRE_NONE;
        endcase
    end

endmodule

// File: rtl/cfss_flags.sv
module cfss_flags
    import cfss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [FLAG_W-1:0] sw_wdata,
    input  cfss_fire_e        fire,
    output logic [FLAG_W-1:0] flags_q
);

    logic [FLAG_W-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        unique case (fire)
            FIRE_XFER: begin
                clr_mask[BIT_XSTEP] = 1'b1;
                clr_mask[BIT_REC]   = 1'b1;
            end
            FIRE_INSN: clr_mask[BIT_REC] = 1'b1;
            default:   clr_mask = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (sw_we) begin
            flags_q <= sw_wdata;
        end else begin
            flags_q <= flags_q & ~clr_mask;
        end
    end

endmodule

// File: rtl/cfss_fsm.sv
module cfss_fsm
    import cfss_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tf_in,
    input  logic        xstep_flag,
    input  cfss_fire_e  fire,
    output cfss_state_e state_q,
    output logic        dbg_req,
    output logic        tf_clr
);

    cfss_state_e state_d;
    cfss_state_e arm_state;

    always_comb begin
        if (tf_in && xstep_flag) begin
            arm_state = ST_STEP_XFER;
        end else if (tf_in) begin
            arm_state = ST_STEP_INSN;
        end else begin
            arm_state = ST_IDLE;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:      state_d = arm_state;
            ST_STEP_INSN: state_d = (fire == FIRE_INSN) ? ST_TRAP_INSN : arm_state;
            ST_STEP_XFER: state_d = (fire == FIRE_XFER) ? ST_TRAP_XFER : arm_state;
            ST_TRAP_INSN: state_d = ST_IDLE;
            ST_TRAP_XFER: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        dbg_req = 1'b0;
        tf_clr  = 1'b0;
        unique case (state_q)
            ST_TRAP_INSN: dbg_req = 1'b1;
            ST_TRAP_XFER: begin
                dbg_req = 1'b1;
                tf_clr  = 1'b1;
            end
            default: begin
                dbg_req = 1'b0;
                tf_clr  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cf_step_ctrl.sv
module cf_step_ctrl
    import cfss_pkg::*;
#(
    parameter int XFER_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tf_in,
    input  logic [XFER_W-1:0] xfer_evt,
    input  logic              retire_evt,
    input  logic              sw_we,
    input  logic [FLAG_W-1:0] sw_wdata,
    output logic [FLAG_W-1:0] ctl_flags,
    output logic              dbg_req,
    output logic              tf_clr
);

    cfss_state_e       state_q;
    cfss_fire_e        fire;
    logic [FLAG_W-1:0] flags_q;

    cfss_trigger #(.XFER_W(XFER_W)) u_trig (
        .state      (state_q),
        .xfer_evt   (xfer_evt),
        .retire_evt (retire_evt),
        .fire       (fire)
    );

    cfss_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .fire     (fire),
        .flags_q  (flags_q)
    );

    cfss_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tf_in      (tf_in),
        .xstep_flag (flags_q[BIT_XSTEP]),
        .fire       (fire),
        .state_q    (state_q),
        .dbg_req    (dbg_req),
        .tf_clr     (tf_clr)
    );

    assign ctl_flags = flags_q;

endmodule

// File: rtl/cf_step_ctrl_chk.sv
module cf_step_ctrl_chk
    import cfss_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sw_we,
    input logic [FLAG_W-1:0] sw_wdata,
    input logic [FLAG_W-1:0] ctl_flags,
    input logic              dbg_req,
    input logic              tf_clr,
    input cfss_state_e       state_q
);

    assert_req_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |=> !dbg_req);

    assert_clr_only_with_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tf_clr |-> dbg_req);

    assert_xfer_req_from_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && tf_clr) |-> ($past(state_q) == ST_STEP_XFER));

    assert_insn_req_from_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !tf_clr) |-> ($past(state_q) == ST_STEP_INSN));

    assert_xfer_autoclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && tf_clr && !$past(sw_we)) |->
            (!ctl_flags[BIT_XSTEP] && !ctl_flags[BIT_REC]));

    assert_msg_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !$past(sw_we)) |-> (ctl_flags[BIT_MSG] == $past(ctl_flags[BIT_MSG])));

    assert_insn_keeps_xstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !tf_clr && !$past(sw_we)) |->
            (!ctl_flags[BIT_REC] && ctl_flags[BIT_XSTEP] == $past(ctl_flags[BIT_XSTEP])));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sw_we) && $past(rst_n)) |-> (ctl_flags == $past(sw_wdata)));

endmodule

bind cf_step_ctrl cf_step_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .ctl_flags (ctl_flags),
    .dbg_req   (dbg_req),
    .tf_clr    (tf_clr),
    .state_q   (state_q)
);

// File: tb/cf_step_ctrl_test.sv
`timescale 1ns/1ps
module cf_step_ctrl_test;

    logic       clk;
    logic       rst_n;
    logic       tf_in;
    logic [2:0] xfer_evt;
    logic       retire_evt;
    logic       sw_we;
    logic [2:0] sw_wdata;
    logic [2:0] ctl_flags;
    logic       dbg_req;
    logic       tf_clr;

    int   n_chk;
    int   n_err;
    bit   done;
    logic tf_b;
    int   m_st;
    logic [2:0] m_fl;

    cf_step_ctrl #(.XFER_W(3)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tf_in      (tf_in),
        .xfer_evt   (xfer_evt),
        .retire_evt (retire_evt),
        .sw_we      (sw_we),
        .sw_wdata   (sw_wdata),
        .ctl_flags  (ctl_flags),
        .dbg_req    (dbg_req),
        .tf_clr     (tf_clr)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic expect_out(input logic req, input logic clr,
                              input logic [2:0] fl, input string tag);
        chk(dbg_req === req, tag, "dbg_req", int'(dbg_req), int'(req));
        chk(tf_clr === clr, tag, "tf_clr", int'(tf_clr), int'(clr));
        chk(ctl_flags === fl, tag, "ctl_flags", int'(ctl_flags), int'(fl));
    endtask

    // Reference state: 0 idle, 1 instruction-armed, 2 transfer-armed,
    // 3 instruction request, 4 transfer request.
    function automatic int ref_next_st(input int st, input logic tf, input logic [2:0] fl,
                                       input logic [2:0] xf, input logic rt);
        if (st == 2 && xf != 3'b000) return 4;
        if (st == 1 && rt) return 3;
        if (st >= 3) return 0;
        if (tf && fl[0]) return 2;
        if (tf) return 1;
        return 0;
    endfunction

    function automatic logic [2:0] ref_next_fl(input int st, input logic [2:0] fl,
                                               input logic we, input logic [2:0] wd,
                                               input logic [2:0] xf, input logic rt);
        if (we) return wd;
        if (st == 2 && xf != 3'b000) return fl & 3'b010;
        if (st == 1 && rt) return fl & 3'b011;
        return fl;
    endfunction

    task automatic cyc(input logic we, input logic [2:0] wd, input logic [2:0] xf,
                       input logic rt, input string tag);
        int         nst;
        logic [2:0] nfl;
        sw_we      = we;
        sw_wdata   = wd;
        xfer_evt   = xf;
        retire_evt = rt;
        tf_in      = tf_b;
        nst = ref_next_st(m_st, tf_b, m_fl, xf, rt);
        nfl = ref_next_fl(m_st, m_fl, we, wd, xf, rt);
        @(posedge clk);
        m_st = nst;
        m_fl = nfl;
        @(negedge clk);
        chk(dbg_req === (m_st >= 3), tag, "model dbg_req", int'(dbg_req), int'(m_st >= 3));
        chk(tf_clr === (m_st == 4), tag, "model tf_clr", int'(tf_clr), int'(m_st == 4));
        chk(ctl_flags === m_fl, tag, "model ctl_flags", int'(ctl_flags), int'(m_fl));
        if (m_st == 4) tf_b = 1'b0;
        sw_we      = 1'b0;
        xfer_evt   = 3'b000;
        retire_evt = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        n_chk = 0; n_err = 0; done = 1'b0;
        tf_b = 1'b0; m_st = 0; m_fl = 3'b000;
        rst_n = 1'b0; tf_in = 1'b0; xfer_evt = '0; retire_evt = 1'b0;
        sw_we = 1'b0; sw_wdata = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        expect_out(1'b0, 1'b0, 3'b000, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(1'b0, 1'b0, 3'b000, "R1");

        // R2 write and read back, arming for transfers
        tf_b = 1'b1;
        cyc(1'b1, 3'b111, 3'b000, 1'b0, "R2");
        expect_out(1'b0, 1'b0, 3'b111, "R2");
        cyc(1'b0, 3'b000, 3'b000, 1'b0, "R2");
        // R3 + R4 taken branch raises request, clears transfer-step and record
        cyc(1'b0, 3'b000, 3'b001, 1'b0, "R3");
        expect_out(1'b1, 1'b1, 3'b010, "R4");
        cyc(1'b0, 3'b000, 3'b000, 1'b0, "R8");
        expect_out(1'b0, 1'b0, 3'b010, "R8");

        // R5 trap flag set again, transfer-step still clear: strobes ignored
        tf_b = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 3'b000, 3'b111, 1'b0, "R5");
            expect_out(1'b0, 1'b0, 3'b010, "R5");
        end

        // R6 instruction stepping
        cyc(1'b1, 3'b110, 3'b000, 1'b0, "R6");
        cyc(1'b0, 3'b000, 3'b000, 1'b0, "R6");
        cyc(1'b0, 3'b000, 3'b000, 1'b1, "R6");
        expect_out(1'b1, 1'b0, 3'b010, "R6");
        // R8 strobes in the two cycles after the triggering one are ignored
        cyc(1'b0, 3'b000, 3'b000, 1'b1, "R8");
        expect_out(1'b0, 1'b0, 3'b010, "R8");
        cyc(1'b0, 3'b000, 3'b000, 1'b1, "R8");
        expect_out(1'b0, 1'b0, 3'b010, "R8");
        cyc(1'b0, 3'b000, 3'b000, 1'b1, "R8");
        expect_out(1'b1, 1'b0, 3'b010, "R8");

        // R7 trap flag low: nothing fires, nothing clears
        tf_b = 1'b0;
        cyc(1'b1, 3'b111, 3'b000, 1'b0, "R7");
        cyc(1'b0, 3'b000, 3'b000, 1'b0, "R7");
        cyc(1'b0, 3'b000, 3'b000, 1'b0, "R7");
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 3'b000, 3'b111, 1'b1, "R7");
            expect_out(1'b0, 1'b0, 3'b111, "R7");
        end

        // R11 then R8 simultaneous strobes
        tf_b = 1'b1;
        cyc(1'b0, 3'b000, 3'b000, 1'b0, "R11");
        cyc(1'b0, 3'b000, 3'b000, 1'b0, "R11");
        cyc(1'b0, 3'b000, 3'b000, 1'b1, "R11");
        expect_out(1'b0, 1'b0, 3'b111, "R11");
        cyc(1'b0, 3'b000, 3'b111, 1'b1, "R8");
        expect_out(1'b1, 1'b1, 3'b010, "R8");
        cyc(1'b0, 3'b000, 3'b111, 1'b0, "R8");
        expect_out(1'b0, 1'b0, 3'b010, "R8");

        // R9 arming lags the write by one cycle
        tf_b = 1'b1;
        cyc(1'b1, 3'b101, 3'b000, 1'b0, "R9");
        cyc(1'b0, 3'b000, 3'b001, 1'b0, "R9");
        expect_out(1'b0, 1'b0, 3'b101, "R9");
        cyc(1'b0, 3'b000, 3'b001, 1'b0, "R9");
        expect_out(1'b1, 1'b1, 3'b000, "R9");

        // R10 write in the same cycle as a firing strobe
        tf_b = 1'b1;
        cyc(1'b1, 3'b101, 3'b000, 1'b0, "R10");
        cyc(1'b0, 3'b000, 3'b000, 1'b0, "R10");
        cyc(1'b0, 3'b000, 3'b000, 1'b0, "R10");
        cyc(1'b1, 3'b011, 3'b100, 1'b0, "R10");
        expect_out(1'b1, 1'b1, 3'b011, "R10");

        // random traffic against the reference model (R3 R6 R8 R10)
        for (int i = 0; i < 3000; i++) begin
            logic       we;
            logic [2:0] wd;
            logic [2:0] xf;
            logic       rt;
            we = ($urandom % 100) < 8;
            wd = 3'($urandom);
            xf = (($urandom % 100) < 30) ? 3'($urandom) : 3'b000;
            rt = ($urandom % 100) < 40;
            if (($urandom % 100) < 10) tf_b = 1'b1;
            if (($urandom % 100) < 3)  tf_b = 1'b0;
            cyc(we, wd, xf, rt, "R3_R6_R10_random");
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule